// File: doc/BRIEF.md
# NAND Flash Bus Cycle Timing Engine

This block converts single byte- or halfword-wide requests (command, address, data write, data read) into the pin waveforms of a parallel NAND flash device. Each request becomes one bus cycle made of three phases:

- a latch setup phase, with the command or address latch line raised and the strobe still high;
- an active phase, with the write or read strobe low;
- a hold phase, after the strobe has returned high.

The length of each phase comes from its own 3-bit timing field, counted in system clocks. A read cycle samples the flash data bus at the instant the read strobe rises and hands the value back with a one-cycle valid pulse.

Alongside the cycle engine, the block watches the flash ready/busy pin for an edge of a programmable polarity and latches it as a flag. It also latches an illegal-access flag whenever a request arrives while the controller is disabled or locked. Each flag can drive the shared interrupt line through its own enable. The chip-enable pin is driven straight from a configuration input. Sequencing of multi-cycle flash operations and error correction are left to the surrounding logic.

Top module: `nand_cycle_engine`

## Requirements
- R1: After a legal request is accepted, the strobe stays high for exactly `cfg_setup` clocks (zero allowed) before it falls, with the latch line for the request kind already raised.
- R2: The active strobe (`nand_we_n` for kinds 0,1,2; `nand_re_n` for kind 3) is low for exactly `cfg_active`+1 clocks, and the other strobe stays high throughout.
- R3: After the strobe rises, the cycle holds for exactly `cfg_hold`+1 clocks, and `req_ready` is low from acceptance until the hold ends.
- R4: Kind encoding is 0 = command (`nand_cle` high), 1 = address (`nand_ale` high), 2 = data write (neither latch high). For these kinds `nand_dq_oe` is high for the whole cycle and `nand_dq_o` carries `req_data`, with bits 15:8 forced to zero when `cfg_wide` is 0.
- R5: Kind 3 = data read. The bus is not driven, `nand_dq_i` is captured on the clock edge where `nand_re_n` rises, and `rd_valid` is high for one clock after that edge with the captured value on `rd_data`. Bits 15:8 of `rd_data` are zero when `cfg_wide` is 0.
- R6: With `cfg_busy_rise` = 1, a low-to-high transition of `nand_rb` sets `rb_flag`; with 0, a high-to-low transition sets it. The opposite transition is ignored. The flag is set within 4 clocks of the pin change; the pin passes through a two-stage synchroniser.
- R7: A `rb_clear` pulse clears `rb_flag`. A clear in the same cycle as a detected edge wins.
- R8: A request accepted while `cfg_enable` is 0 or `cfg_lock` is 1 produces no strobe or latch activity, returns `req_ready` high on the next clock, and sets `ill_flag`. `ill_clear` clears `ill_flag`.
- R9: `irq` is high exactly when (`rb_flag` and `irq_rb_en`) or (`ill_flag` and `irq_ill_en`).
- R10: `nand_ce_n` follows `cfg_ce_n` directly, 0 meaning selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_setup | input | 3 | Latch setup length in clocks |
| cfg_active | input | 3 | Strobe low length minus one |
| cfg_hold | input | 3 | Hold length minus one |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cfg_busy_rise | input | 1 | 1 = detect rising ready/busy, 0 = falling |
| cfg_enable | input | 1 | Controller master enable |
| cfg_lock | input | 1 | Requests refused while set |
| cfg_ce_n | input | 1 | Chip-enable level, 0 selects |
| irq_rb_en | input | 1 | Ready/busy interrupt enable |
| irq_ill_en | input | 1 | Illegal-access interrupt enable |
| rb_clear | input | 1 | Clears the ready/busy flag |
| ill_clear | input | 1 | Clears the illegal-access flag |
| req_valid | input | 1 | Request present |
| req_kind | input | 2 | 0 cmd, 1 addr, 2 write, 3 read |
| req_data | input | 16 | Command, address or write data |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 16 | Captured read data |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_dq_o | output | 16 | Data bus out |
| nand_dq_oe | output | 1 | Data bus drive enable |
| nand_dq_i | input | 16 | Data bus in |
| nand_rb | input | 1 | Ready/busy pin |
| rb_flag | output | 1 | Ready/busy edge seen |
| ill_flag | output | 1 | Illegal access seen |
| irq | output | 1 | Combined interrupt |

## Verification
The cycle engine is driven with every request kind. The three timing fields are taken at zero, at their maximum of seven and at mixed values, so that a phase counted one clock short or long, or two fields swapped, shows up as a wrong phase length.

Writes and reads are run in both bus widths, with data whose upper and lower bytes differ, which separates correct masking from passing the full word.

Ready/busy is toggled in both directions under each polarity, so detection of the wrong edge is exposed. Illegal requests are issued under disable and under lock separately. The interrupt is checked with each enable on and off.

// File: rtl/nand_cycle_engine.sv
module nand_cycle_engine (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  cfg_setup,
  input  logic [2:0]  cfg_active,
  input  logic [2:0]  cfg_hold,
  input  logic        cfg_wide,
  input  logic        cfg_busy_rise,
  input  logic        cfg_enable,
  input  logic        cfg_lock,
  input  logic        cfg_ce_n,
  input  logic        irq_rb_en,
  input  logic        irq_ill_en,
  input  logic        rb_clear,
  input  logic        ill_clear,
  input  logic        req_valid,
  input  logic [1:0]  req_kind,
  input  logic [15:0] req_data,
  output logic        req_ready,
  output logic        rd_valid,
  output logic [15:0] rd_data,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic        nand_ce_n,
  output logic [15:0] nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [15:0] nand_dq_i,
  input  logic        nand_rb,
  output logic        rb_flag,
  output logic        ill_flag,
  output logic        irq
);
  typedef enum logic [1:0] {IDLE, SETUP, ACTIVE, HOLD} phase_t;
  localparam logic [1:0] K_CMD = 2'd0, K_ADDR = 2'd1, K_READ = 2'd3;

  phase_t      phase;
  logic [2:0]  cnt;
  logic [1:0]  kind;
  logic [15:0] wdata;
  logic        rb_s1, rb_s2, rb_prev;

  wire take    = req_valid && req_ready;
  wire allowed = cfg_enable && !cfg_lock;
  wire busy    = phase != IDLE;
  wire is_read = kind == K_READ;
  wire rb_edge = cfg_busy_rise ? (rb_s2 && !rb_prev) : (!rb_s2 && rb_prev);

  assign req_ready  = phase == IDLE;
  assign nand_cle   = busy && kind == K_CMD;
  assign nand_ale   = busy && kind == K_ADDR;
  assign nand_we_n  = !(phase == ACTIVE && !is_read);
  assign nand_re_n  = !(phase == ACTIVE && is_read);
  assign nand_dq_oe = busy && !is_read;
  assign nand_dq_o  = cfg_wide ? wdata : {8'h00, wdata[7:0]};
  assign nand_ce_n  = cfg_ce_n;
  assign irq        = (rb_flag && irq_rb_en) || (ill_flag && irq_ill_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= IDLE;
      cnt      <= '0;
      kind     <= '0;
      wdata    <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (phase)
        IDLE: if (take && allowed) begin
          kind  <= req_kind;
          wdata <= req_data;
          if (cfg_setup != 3'd0) begin
            phase <= SETUP;
            cnt   <= cfg_setup - 3'd1;
          end else begin
            phase <= ACTIVE;
            cnt   <= cfg_active;
          end
        end
        SETUP: if (cnt == 3'd0) begin
          phase <= ACTIVE;
          cnt   <= cfg_active;
        end else cnt <= cnt - 3'd1;
        ACTIVE: if (cnt == 3'd0) begin
          phase <= HOLD;
          cnt   <= cfg_hold;
          if (is_read) begin
            rd_valid <= 1'b1;
            rd_data  <= cfg_wide ? nand_dq_i : {8'h00, nand_dq_i[7:0]};
          end
        end else cnt <= cnt - 3'd1;
        HOLD: if (cnt == 3'd0) phase <= IDLE;
              else cnt <= cnt - 3'd1;
        default: phase <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_s1    <= 1'b1;
      rb_s2    <= 1'b1;
      rb_prev  <= 1'b1;
      rb_flag  <= 1'b0;
      ill_flag <= 1'b0;
    end else begin
      rb_s1   <= nand_rb;
      rb_s2   <= rb_s1;
      rb_prev <= rb_s2;
      if (rb_clear)     rb_flag <= 1'b0;
      else if (rb_edge) rb_flag <= 1'b1;
      if (ill_clear)              ill_flag <= 1'b0;
      else if (take && !allowed)  ill_flag <= 1'b1;
    end
  end
endmodule

// File: rtl/nand_cycle_engine_chk.sv
module nand_cycle_engine_chk (
  input logic clk,
  input logic rst_n,
  input logic cfg_enable,
  input logic cfg_lock,
  input logic irq_rb_en,
  input logic irq_ill_en,
  input logic ill_clear,
  input logic req_valid,
  input logic req_ready,
  input logic rd_valid,
  input logic nand_cle,
  input logic nand_ale,
  input logic nand_we_n,
  input logic nand_re_n,
  input logic ill_flag,
  input logic irq
);
  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  assert_busy_when_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!nand_we_n || !nand_re_n) |-> !req_ready);
  assert_latch_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  assert_rdvalid_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!nand_re_n) && nand_re_n);
  assert_illegal_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (!cfg_enable || cfg_lock) && !ill_clear) |=> (ill_flag && req_ready));
  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_rb_en && !irq_ill_en) |-> !irq);
endmodule

bind nand_cycle_engine nand_cycle_engine_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_lock(cfg_lock),
  .irq_rb_en(irq_rb_en), .irq_ill_en(irq_ill_en), .ill_clear(ill_clear),
  .req_valid(req_valid), .req_ready(req_ready), .rd_valid(rd_valid),
  .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
  .nand_re_n(nand_re_n), .ill_flag(ill_flag), .irq(irq)
);

// File: tb/sim_nand_cycle_engine.sv
`timescale 1ns/1ps
module sim_nand_cycle_engine;
  logic clk = 0, rst_n = 0;
  logic [2:0] cfg_setup = 0, cfg_active = 0, cfg_hold = 0;
  logic cfg_wide = 0, cfg_busy_rise = 1, cfg_enable = 1, cfg_lock = 0, cfg_ce_n = 1;
  logic irq_rb_en = 0, irq_ill_en = 0, rb_clear = 0, ill_clear = 0;
  logic req_valid = 0;
  logic [1:0] req_kind = 0;
  logic [15:0] req_data = 0, nand_dq_i = 16'hA5C3;
  logic nand_rb = 1;
  logic req_ready, rd_valid, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_ce_n;
  logic nand_dq_oe, rb_flag, ill_flag, irq;
  logic [15:0] rd_data, nand_dq_o;
  int tests = 0, fails = 0;

  always #4 clk = ~clk;

  nand_cycle_engine u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset();
    chk(req_ready && nand_we_n && nand_re_n && !nand_cle && !nand_ale && !rd_valid
        && !rb_flag && !ill_flag && !irq && !nand_dq_oe, "R3 reset", 0, 0);
  endtask

  task automatic t_cycle(input logic [1:0] k, input logic [15:0] d, input int s, input int a,
                         input int h, input logic w);
    int pre = 0, act = 0, post = 0;
    logic [15:0] seen = 0, rv = 0;
    logic gotv = 0, latch_ok = 1, oe_ok = 1, other_ok = 1;
    logic [15:0] exp_w, exp_r;
    cfg_setup = 3'(s); cfg_active = 3'(a); cfg_hold = 3'(h); cfg_wide = w;
    exp_w = w ? d : {8'h00, d[7:0]};
    exp_r = w ? nand_dq_i : {8'h00, nand_dq_i[7:0]};
    @(negedge clk); req_kind = k; req_data = d; req_valid = 1;
    @(negedge clk); req_valid = 0;
    for (int i = 0; i < 64; i++) begin
      logic st, ot;
      if (req_ready) break;
      st = (k == 2'd3) ? nand_re_n : nand_we_n;
      ot = (k == 2'd3) ? nand_we_n : nand_re_n;
      if (!ot) other_ok = 0;
      if (!st) begin act++; seen = nand_dq_o; end
      else if (act == 0) pre++;
      else post++;
      if (nand_cle != (k == 2'd0) || nand_ale != (k == 2'd1)) latch_ok = 0;
      if (nand_dq_oe != (k != 2'd3)) oe_ok = 0;
      if (rd_valid) begin gotv = 1; rv = rd_data; end
      @(negedge clk);
    end
    chk(pre == s, "R1 setup length", pre, s);
    chk(act == a + 1 && other_ok, "R2 strobe length", act, a + 1);
    chk(post == h + 1, "R3 hold length", post, h + 1);
    chk(latch_ok, "R4 latch lines", k, k);
    if (k != 2'd3) begin
      chk(oe_ok && seen == exp_w, "R4 write data", seen, exp_w);
    end else begin
      chk(oe_ok && gotv && rv == exp_r, "R5 read data", rv, exp_r);
      chk(!rd_valid, "R5 valid single pulse", rd_valid, 0);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_rb_clear();
    rb_clear = 1; @(negedge clk); rb_clear = 0;
  endtask

  task automatic t_ready_busy();
    cfg_busy_rise = 1;
    nand_rb = 0; wait_clk(5);
    chk(!rb_flag, "R6 falling ignored in rise mode", rb_flag, 0);
    nand_rb = 1; wait_clk(5);
    chk(rb_flag, "R6 rising detected", rb_flag, 1);
    pulse_rb_clear();
    chk(!rb_flag, "R7 clear", rb_flag, 0);
    cfg_busy_rise = 0;
    nand_rb = 0; wait_clk(5);
    chk(rb_flag, "R6 falling detected", rb_flag, 1);
    pulse_rb_clear();
    nand_rb = 1; wait_clk(5);
    chk(!rb_flag, "R6 rising ignored in fall mode", rb_flag, 0);
    nand_rb = 0; wait_clk(2);
    rb_clear = 1; wait_clk(3); rb_clear = 0; @(negedge clk);
    chk(!rb_flag, "R7 clear beats edge", rb_flag, 0);
    nand_rb = 1; cfg_busy_rise = 1; wait_clk(5); pulse_rb_clear();
  endtask

  task automatic t_illegal(input logic en, input logic lk);
    logic quiet = 1;
    cfg_enable = en; cfg_lock = lk;
    @(negedge clk); req_kind = 2'd0; req_valid = 1;
    @(negedge clk); req_valid = 0;
    chk(req_ready, "R8 ready after illegal", req_ready, 1);
    for (int i = 0; i < 6; i++) begin
      if (!nand_we_n || !nand_re_n || nand_cle || nand_ale) quiet = 0;
      @(negedge clk);
    end
    chk(quiet && ill_flag, "R8 illegal no cycle", ill_flag, 1);
    ill_clear = 1; @(negedge clk); ill_clear = 0;
    chk(!ill_flag, "R8 ill clear", ill_flag, 0);
    cfg_enable = 1; cfg_lock = 0;
  endtask

  task automatic t_irq();
    nand_rb = 0; wait_clk(3); nand_rb = 1; wait_clk(5);
    irq_rb_en = 0; irq_ill_en = 1; @(negedge clk);
    chk(rb_flag && !irq, "R9 rb masked", irq, 0);
    irq_rb_en = 1; @(negedge clk);
    chk(irq, "R9 rb enabled", irq, 1);
    pulse_rb_clear(); irq_rb_en = 0;
    cfg_lock = 1;
    @(negedge clk); req_valid = 1; @(negedge clk); req_valid = 0; cfg_lock = 0;
    chk(irq, "R9 ill enabled", irq, 1);
    irq_ill_en = 0; @(negedge clk);
    chk(!irq, "R9 ill masked", irq, 0);
    ill_clear = 1; @(negedge clk); ill_clear = 0;
  endtask

  task automatic t_ce();
    cfg_ce_n = 0; #1;
    chk(nand_ce_n == 0, "R10 ce low", nand_ce_n, 0);
    cfg_ce_n = 1; #1;
    chk(nand_ce_n == 1, "R10 ce high", nand_ce_n, 1);
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    wait_clk(3); rst_n = 1; @(negedge clk);
    t_reset();
    t_cycle(2'd0, 16'h1270, 2, 1, 0, 0);
    t_cycle(2'd1, 16'h3C5A, 0, 0, 0, 0);
    t_cycle(2'd2, 16'hBEEF, 7, 7, 7, 1);
    t_cycle(2'd2, 16'hBEEF, 3, 2, 5, 0);
    t_cycle(2'd3, 16'h0000, 1, 4, 2, 1);
    t_cycle(2'd3, 16'h0000, 0, 0, 3, 0);
    t_ready_busy();
    t_illegal(0, 0);
    t_illegal(1, 1);
    t_irq();
    t_ce();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule